// File: doc/BRIEF.md
# Half-Duplex SPI Master

This block is a register-mapped SPI master that runs one half-duplex transaction each time software issues a start command. A transaction has up to three consecutive phases. A command phase sends up to four bytes taken from an opcode word. A transmit phase sends further bytes from a 32-byte data buffer. A receive phase captures bytes from the slave into that same buffer. Software sets the length of each phase in a single length register, starts the transaction, and polls a busy flag until the bus goes quiet.

The configuration register sets the SCK divider, clock polarity, clock phase and bit order. Chip selects are driven from a register of their own and do not follow the transaction. Software can therefore hold one slave selected across several transactions, for example a command transaction followed by a read transaction. Inputs are a simple synchronous write strobe with a byte address, and a combinational read-data path.

Top module: `spi_hd_master`

## Requirements
- R1: After reset all chip-select outputs are high, SCK and MOSI are low, the busy flag (bit 16 at offset 0x00) reads 0, and the configuration word at offset 0x28 reads 0xE000_0000.
- R2: Writing a word with bit 8 set to offset 0x00 while idle sets the busy flag from the next cycle. The flag drops after the final SCK edge of the transaction.
- R3: The command phase length is bits 31:24 of the length word (offset 0x2C) divided by 8, with anything above 4 treated as 4. Command bytes leave the opcode word (offset 0x04) starting at its highest used byte position and moving downward.
- R4: One SCK period lasts the value of configuration bits 27:16 plus 2 system clocks.
- R5: Configuration bit 4 sets the idle SCK level. With configuration bit 5 clear, MISO is sampled on the first edge of each bit and MOSI changes on the second edge. With bit 5 set, MOSI changes on the first edge and MISO is sampled on the second. SCK is back at its idle level when busy drops.
- R6: Configuration bit 3 set sends and receives each byte least significant bit first; clear means most significant bit first.
- R7: The transmit phase sends bits 8:0 of the length word divided by 8 (at most 32) bytes from the buffer at offsets 0x08 to 0x24. Byte 0 is bits 7:0 of the word at 0x08, packed little-endian. MOSI is 0 during the receive phase.
- R8: The receive phase captures bits 20:12 of the length word divided by 8 (at most 32) bytes. They are stored little-endian from byte 0 of the buffer, and buffer bytes beyond that count keep their contents. Length values that are not multiples of 8 are rounded down.
- R9: Each chip-select output i is low exactly while bit i of the register at offset 0x38 is 1. It changes only on a write to that register, independent of transactions.
- R10: While busy, writes to the configuration, length, opcode and buffer registers and further start commands have no effect.
- R11: With all three lengths zero, a start sets busy for exactly one cycle, and SCK does not toggle.
- R12: Reading offset 0x00 returns the busy flag in bit 16 and zero in every other bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 6 | Register byte address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the slave |
| spi_miso | input | 1 | Serial data from the slave |
| spi_cs_n | output | 8 | Active-low chip selects |

## Verification
The assertions assume software never changes the configuration during a transaction. They also assume the slave changes MISO only on the edge opposite the design's sampling edge. The bench keeps within both assumptions. Its slave model reacts to SCK edges in the mode chosen for the run, and configuration writes are issued only while idle, except in the test that checks those writes are ignored. After every mode change the bench lets SCK settle at its new idle level before it resets the slave model, so the level change is not counted as a clock edge.

// File: rtl/spim_pkg.sv
package spim_pkg;
    localparam int BUF_WORDS = 8;
    localparam int BUF_BYTES = 4 * BUF_WORDS;
    localparam int IDX_W     = $clog2(BUF_BYTES);
    localparam int CNT_W     = IDX_W + 2;
    localparam int DIV_W     = 12;
    localparam int NUM_CS    = 8;
    localparam int ADDR_W    = 6;

    localparam logic [ADDR_W-1:0] ADR_CTRL = 6'h00;
    localparam logic [ADDR_W-1:0] ADR_OPC  = 6'h04;
    localparam logic [ADDR_W-1:0] ADR_BUF0 = 6'h08;
    localparam logic [ADDR_W-1:0] ADR_CFG  = 6'h28;
    localparam logic [ADDR_W-1:0] ADR_LEN  = 6'h2C;
    localparam logic [ADDR_W-1:0] ADR_CS   = 6'h38;

    localparam int CTRL_GO   = 8;
    localparam int CTRL_BUSY = 16;
    localparam int CFG_LSB   = 3;
    localparam int CFG_CPOL  = 4;
    localparam int CFG_CPHA  = 5;
    localparam int CFG_DIV   = 16;
    localparam logic [31:0] CFG_RESET = 32'hE000_0000;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_RUN,
        SQ_DONE
    } seq_state_e;
endpackage

// File: rtl/spim_baud.sv
module spim_baud
    import spim_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             half,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    localparam int PW = DIV_W + 1;

    typedef struct packed {
        logic [PW-1:0] cnt;
    } baud_t;

    baud_t b_d, b_q;
    logic [PW-1:0] period, len_lo, len_hi, limit;

    always_comb begin
        period = {1'b0, div} + PW'(2);
        len_lo = period >> 1;
        len_hi = period - len_lo;
        limit  = half ? len_hi : len_lo;
        tick   = run && (b_q.cnt == limit - PW'(1));
        b_d    = b_q;
        if (!run || tick) b_d.cnt = '0;
        else              b_d.cnt = b_q.cnt + PW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) b_q <= '0;
        else        b_q <= b_d;
    end

    AST_HALF_WITHIN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (b_q.cnt < limit)); // R4
endmodule

// File: rtl/spim_engine.sv
module spim_engine
    import spim_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [2:0]             cmd_n,
    input  logic [IDX_W:0]         tx_n,
    input  logic [IDX_W:0]         rx_n,
    input  logic [31:0]            opcode,
    input  logic [8*BUF_BYTES-1:0] buf_flat,
    input  logic                   cpol,
    input  logic                   cpha,
    input  logic                   lsb_first,
    input  logic                   tick,
    input  logic                   miso,
    output logic                   busy,
    output logic                   run,
    output logic                   half,
    output logic                   sck,
    output logic                   mosi,
    output logic                   rx_we,
    output logic [IDX_W-1:0]       rx_idx,
    output logic [7:0]             rx_byte
);
    typedef struct packed {
        seq_state_e       st;
        logic             half;
        logic             sck;
        logic             mosi;
        logic [2:0]       bitn;
        logic [CNT_W-1:0] pos;
        logic [7:0]       txb;
        logic [7:0]       rxb;
        logic [CNT_W-1:0] ncmd;
        logic [CNT_W-1:0] nsend;
        logic [CNT_W-1:0] nall;
    } seq_t;

    seq_t s_d, s_q;

    function automatic logic [7:0] byte_at(input logic [CNT_W-1:0] p,
                                           input logic [CNT_W-1:0] nc,
                                           input logic [CNT_W-1:0] ns,
                                           input logic [31:0] opc,
                                           input logic [8*BUF_BYTES-1:0] bf);
        logic [31:0]            o;
        logic [8*BUF_BYTES-1:0] b;
        int                     k;
        if (p < nc) begin
            k = int'(nc) - 1 - int'(p);
            o = opc >> (8 * k);
            return o[7:0];
        end
        if (p < ns) begin
            k = int'(p) - int'(nc);
            b = bf >> (8 * k);
            return b[7:0];
        end
        return 8'h00;
    endfunction

    logic [2:0]       bpos, nbit, npos_bit;
    logic [7:0]       first, nxt, rx_cur;
    logic [CNT_W-1:0] nc_new, ns_new, na_new;

    always_comb begin
        s_d      = s_q;
        rx_we    = 1'b0;
        rx_byte  = s_q.rxb;
        rx_cur   = s_q.rxb;
        bpos     = lsb_first ? s_q.bitn : 3'd7 - s_q.bitn;
        nbit     = s_q.bitn + 3'd1;
        npos_bit = lsb_first ? nbit : 3'd7 - nbit;
        nc_new   = CNT_W'(cmd_n);
        ns_new   = nc_new + CNT_W'(tx_n);
        na_new   = ns_new + CNT_W'(rx_n);
        first    = byte_at('0, nc_new, ns_new, opcode, buf_flat);
        nxt      = byte_at(s_q.pos + CNT_W'(1), s_q.ncmd, s_q.nsend, opcode, buf_flat);
        case (s_q.st)
            SQ_IDLE: begin
                s_d.sck = cpol;
                if (start) begin
                    s_d.ncmd  = nc_new;
                    s_d.nsend = ns_new;
                    s_d.nall  = na_new;
                    s_d.half  = 1'b0;
                    s_d.bitn  = '0;
                    s_d.pos   = '0;
                    s_d.rxb   = '0;
                    s_d.txb   = first;
                    if (na_new == '0) begin
                        s_d.st = SQ_DONE;
                    end else begin
                        s_d.st = SQ_RUN;
                        if (!cpha) s_d.mosi = lsb_first ? first[0] : first[7];
                    end
                end
            end
            SQ_DONE: s_d.st = SQ_IDLE;
            SQ_RUN: begin
                if (tick) begin
                    if (!s_q.half) begin
                        s_d.sck  = ~cpol;
                        s_d.half = 1'b1;
                        if (!cpha) s_d.rxb[bpos] = miso;
                        else       s_d.mosi      = s_q.txb[bpos];
                    end else begin
                        s_d.sck  = cpol;
                        s_d.half = 1'b0;
                        if (cpha) rx_cur[bpos] = miso;
                        if (s_q.bitn == 3'd7) begin
                            if (s_q.pos >= s_q.nsend) begin
                                rx_we   = 1'b1;
                                rx_byte = rx_cur;
                            end
                            if (s_q.pos == s_q.nall - CNT_W'(1)) begin
                                s_d.st = SQ_IDLE;
                            end else begin
                                s_d.pos  = s_q.pos + CNT_W'(1);
                                s_d.txb  = nxt;
                                s_d.rxb  = '0;
                                s_d.bitn = '0;
                                if (!cpha) s_d.mosi = lsb_first ? nxt[0] : nxt[7];
                            end
                        end else begin
                            s_d.bitn = nbit;
                            s_d.rxb  = rx_cur;
                            if (!cpha) s_d.mosi = s_q.txb[npos_bit];
                        end
                    end
                end
            end
            default: s_d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: SQ_IDLE, default: '0};
        else        s_q <= s_d;
    end

    assign busy   = (s_q.st != SQ_IDLE);
    assign run    = (s_q.st == SQ_RUN);
    assign half   = s_q.half;
    assign sck    = s_q.sck;
    assign mosi   = s_q.mosi;
    assign rx_idx = IDX_W'(s_q.pos - s_q.nsend);

    AST_RX_PHASE_MOSI_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == SQ_RUN && s_q.half && s_q.pos >= s_q.nsend) |-> !s_q.mosi); // R7
    AST_SCK_IDLE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (s_q.sck == cpol)); // R5
    AST_EMPTY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == SQ_DONE) |=> !busy); // R11
    AST_RX_WRITE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_we |-> (int'(s_q.pos) - int'(s_q.nsend) < BUF_BYTES)); // R8
endmodule

// File: rtl/spi_hd_master.sv
module spi_hd_master
    import spim_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              spi_sck,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic [NUM_CS-1:0] spi_cs_n
);
    typedef struct packed {
        logic [31:0]            opc;
        logic [8*BUF_BYTES-1:0] dbuf;
        logic [31:0]            cfg;
        logic [31:0]            len;
        logic [NUM_CS-1:0]      cs;
    } regs_t;

    regs_t r_d, r_q;

    logic             busy, run, half, tick, start, rx_we;
    logic [IDX_W-1:0] rx_idx;
    logic [7:0]       rx_byte;
    logic [2:0]       cmd_n;
    logic [IDX_W:0]   tx_n, rx_n;
    logic [4:0]       cmd_raw;
    logic [5:0]       tx_raw, rx_raw;
    logic             in_buf;
    logic [ADDR_W-1:0] buf_off;
    logic [8*BUF_BYTES-1:0] rd_shift;

    always_comb begin
        cmd_raw = r_q.len[31:27];
        tx_raw  = r_q.len[8:3];
        rx_raw  = r_q.len[20:15];
        cmd_n   = (cmd_raw > 5'd4) ? 3'd4 : cmd_raw[2:0];
        tx_n    = (int'(tx_raw) > BUF_BYTES) ? (IDX_W+1)'(BUF_BYTES) : (IDX_W+1)'(tx_raw);
        rx_n    = (int'(rx_raw) > BUF_BYTES) ? (IDX_W+1)'(BUF_BYTES) : (IDX_W+1)'(rx_raw);
    end

    always_comb begin
        in_buf  = (bus_addr >= ADR_BUF0) && (bus_addr < ADR_BUF0 + ADDR_W'(4 * BUF_WORDS));
        buf_off = bus_addr - ADR_BUF0;
        start   = bus_we && !busy && (bus_addr == ADR_CTRL) && bus_wdata[CTRL_GO];
        r_d     = r_q;
        if (bus_we) begin
            if (bus_addr[ADDR_W-1:2] == ADR_CS[ADDR_W-1:2]) r_d.cs = bus_wdata[NUM_CS-1:0];
            if (!busy) begin
                if (bus_addr[ADDR_W-1:2] == ADR_OPC[ADDR_W-1:2]) r_d.opc = bus_wdata;
                if (bus_addr[ADDR_W-1:2] == ADR_CFG[ADDR_W-1:2]) r_d.cfg = bus_wdata;
                if (bus_addr[ADDR_W-1:2] == ADR_LEN[ADDR_W-1:2]) r_d.len = bus_wdata;
                if (in_buf) r_d.dbuf[32*int'(buf_off[ADDR_W-1:2]) +: 32] = bus_wdata;
            end
        end
        if (rx_we) r_d.dbuf[8*int'(rx_idx) +: 8] = rx_byte;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{cfg: CFG_RESET, default: '0};
        else        r_q <= r_d;
    end

    always_comb begin
        bus_rdata = '0;
        rd_shift  = r_q.dbuf >> (32 * int'(buf_off[ADDR_W-1:2]));
        if (in_buf) bus_rdata = rd_shift[31:0];
        else begin
            case (bus_addr[ADDR_W-1:2])
                ADR_CTRL[ADDR_W-1:2]: bus_rdata[CTRL_BUSY] = busy;
                ADR_OPC[ADDR_W-1:2]:  bus_rdata = r_q.opc;
                ADR_CFG[ADDR_W-1:2]:  bus_rdata = r_q.cfg;
                ADR_LEN[ADDR_W-1:2]:  bus_rdata = r_q.len;
                ADR_CS[ADDR_W-1:2]:   bus_rdata[NUM_CS-1:0] = r_q.cs;
                default:              bus_rdata = '0;
            endcase
        end
    end

    assign spi_cs_n = ~r_q.cs;

    spim_baud i_baud (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .half  (half),
        .div   (r_q.cfg[CFG_DIV +: DIV_W]),
        .tick  (tick)
    );

    spim_engine i_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .cmd_n     (cmd_n),
        .tx_n      (tx_n),
        .rx_n      (rx_n),
        .opcode    (r_q.opc),
        .buf_flat  (r_q.dbuf),
        .cpol      (r_q.cfg[CFG_CPOL]),
        .cpha      (r_q.cfg[CFG_CPHA]),
        .lsb_first (r_q.cfg[CFG_LSB]),
        .tick      (tick),
        .miso      (spi_miso),
        .busy      (busy),
        .run       (run),
        .half      (half),
        .sck       (spi_sck),
        .mosi      (spi_mosi),
        .rx_we     (rx_we),
        .rx_idx    (rx_idx),
        .rx_byte   (rx_byte)
    );

    AST_CFG_HELD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(r_q.cfg)); // R10
    AST_LEN_HELD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(r_q.len)); // R10
    AST_CS_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && bus_addr[ADDR_W-1:2] == ADR_CS[ADDR_W-1:2]) |=> $stable(spi_cs_n)); // R9
    AST_BUSY_NEEDS_GO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(bus_we && bus_addr == ADR_CTRL && bus_wdata[CTRL_GO])); // R2
endmodule

// File: tb/test_spi_hd_master.sv
module test_spi_hd_master;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        spi_sck, spi_mosi;
    logic        spi_miso = 1'b0;
    logic [7:0]  spi_cs_n;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    logic cpol_t = 0, cpha_t = 0, lsb_t = 0;
    logic cap [0:2047];
    int cap_n = 0, miso_n = 0, lead_n = 0, lead_c0 = 0, lead_c1 = 0, vsel = 0;

    spi_hd_master i_spi_hd_master (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sck(spi_sck),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n));

    always #4 clk = ~clk;

    // fields: [31:30] mode, [29] lsb, [28:26] cmd bytes, [25:20] tx bytes, [19:14] rx bytes, [13:2] div
    localparam logic [31:0] VEC [7] = '{
        {2'd0, 1'b0, 3'd1, 6'd2, 6'd2,  12'd0, 2'd0},
        {2'd1, 1'b0, 3'd4, 6'd0, 6'd3,  12'd1, 2'd0},
        {2'd2, 1'b1, 3'd2, 6'd3, 6'd1,  12'd2, 2'd0},
        {2'd3, 1'b1, 3'd3, 6'd1, 6'd0,  12'd3, 2'd0},
        {2'd0, 1'b1, 3'd0, 6'd5, 6'd4,  12'd5, 2'd0},
        {2'd3, 1'b0, 3'd0, 6'd0, 6'd5,  12'd0, 2'd0},
        {2'd0, 1'b0, 3'd0, 6'd0, 6'd32, 12'd0, 2'd0}
    };

    function automatic logic [7:0] mb(input int i);
        return 8'hC5 ^ 8'(i * 13 + vsel);
    endfunction
    function automatic logic [7:0] bb(input int i);
        return 8'(8'h30 + 7 * i + vsel);
    endfunction
    function automatic logic [31:0] opc_of(input int v);
        return 32'hA1B2C3D4 ^ (32'h1111_1111 * 32'(v));
    endfunction
    function automatic logic sbit(input int k);
        logic [7:0] b;
        b = mb(k / 8);
        return lsb_t ? b[k % 8] : b[7 - k % 8];
    endfunction

    initial forever begin
        @(posedge clk);
        cyc++;
        if (cyc > 150000) begin
            total++; bad++;
            $display("FAIL watchdog act=%0d exp=<150000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    always @(spi_sck) begin
        logic lead;
        lead = (spi_sck != cpol_t);
        if (lead) begin
            if (lead_n == 0) lead_c0 = cyc;
            if (lead_n == 1) lead_c1 = cyc;
            lead_n++;
        end
        if ((cpha_t == 1'b0) == lead) begin
            cap[cap_n] = spi_mosi;
            cap_n++;
        end else if (lead) begin
            spi_miso = sbit(miso_n);
            miso_n++;
        end else begin
            miso_n++;
            spi_miso = sbit(miso_n);
        end
    end

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic slave_reset();
        cap_n = 0; miso_n = 0; lead_n = 0;
        spi_miso = cpha_t ? 1'b0 : sbit(0);
    endtask

    task automatic set_mode(input logic [1:0] mode, input logic lsb, input logic [11:0] div);
        cpol_t = mode[1]; cpha_t = mode[0]; lsb_t = lsb;
        wr(6'h28, 32'hE000_0000 | ({20'd0, div} << 16) | {26'd0, mode[0], mode[1], lsb, 3'd0});
        @(negedge clk);
        @(negedge clk);
        slave_reset();
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        forever begin
            rd(6'h00, v);
            if (!v[16]) break;
            @(negedge clk);
        end
    endtask

    task automatic run_xfer(input logic [1:0] mode, input logic lsb, input logic [11:0] div,
                            input logic [31:0] lenv, input int nc, input int nt, input int nr,
                            input int v, input logic poke);
        logic [31:0] w, exp_w, cfg_before;
        logic [7:0]  got, expb;
        int          ok, nbytes;
        vsel = v;
        set_mode(mode, lsb, div);
        wr(6'h04, opc_of(v));
        for (int i = 0; i < 8; i++)
            wr(6'(8 + 4 * i), {bb(4*i+3), bb(4*i+2), bb(4*i+1), bb(4*i)});
        wr(6'h2C, lenv);
        rd(6'h28, cfg_before);
        wr(6'h00, 32'h100);
        if (poke) begin
            wr(6'h28, 32'h0000_0010);
            wr(6'h2C, 32'h0);
            wr(6'h24, 32'hDEADBEEF);
            wr(6'h04, 32'h0);
            wr(6'h00, 32'h100);
        end
        wait_idle();
        nbytes = nc + nt + nr;
        // R3 R6 R7: bytes on MOSI in order
        ok = (cap_n == 8 * nbytes);
        got = 0; expb = 0;
        for (int b = 0; b < nbytes && ok; b++) begin
            for (int j = 0; j < 8; j++) got[lsb ? j : 7 - j] = cap[8 * b + j];
            if (b < nc) begin
                w = opc_of(v) >> (8 * (nc - 1 - b));
                expb = w[7:0];
            end else if (b < nc + nt) expb = bb(b - nc);
            else expb = 8'h00;
            if (got != expb) ok = 0;
        end
        chk(ok != 0, $sformatf("R3/R6/R7 mosi v%0d", v), {24'd0, got}, {24'd0, expb});
        // R8: buffer after receive
        ok = 1; w = 0; exp_w = 0;
        for (int i = 0; i < 8 && ok; i++) begin
            rd(6'(8 + 4 * i), w);
            for (int k = 0; k < 4; k++)
                exp_w[8*k +: 8] = (4*i+k < nr) ? mb(nc + nt + 4*i + k) : bb(4*i+k);
            if (w != exp_w) ok = 0;
        end
        chk(ok != 0, $sformatf("R8 rx buffer v%0d", v), w, exp_w);
        // R2 R11: edge count, second start ignored when poking (R10)
        chk(lead_n == 8 * nbytes, $sformatf("R2 edge count v%0d", v), 32'(lead_n), 32'(8 * nbytes));
        if (nbytes > 0)
            chk(lead_c1 - lead_c0 == int'(div) + 2, $sformatf("R4 period v%0d", v),
                32'(lead_c1 - lead_c0), 32'(div) + 2);
        chk(spi_sck == mode[1], $sformatf("R5 idle level v%0d", v), {31'd0, spi_sck}, {31'd0, mode[1]});
        if (poke) begin
            rd(6'h28, w);
            chk(w == cfg_before, "R10 cfg kept", w, cfg_before);
            rd(6'h2C, w);
            chk(w == lenv, "R10 len kept", w, lenv);
        end
    endtask

    initial begin
        logic [31:0] r;
        logic [31:0] lv;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(spi_cs_n == 8'hFF, "R1 cs_n", {24'd0, spi_cs_n}, 32'hFF);
        chk(spi_sck == 1'b0 && spi_mosi == 1'b0, "R1 sck/mosi", {30'd0, spi_sck, spi_mosi}, 32'd0);
        rd(6'h28, r);
        chk(r == 32'hE000_0000, "R1 cfg", r, 32'hE000_0000);
        rd(6'h00, r);
        chk(r == 32'd0, "R12 ctrl idle", r, 32'd0);

        // R9 chip select under software control
        wr(6'h38, 32'h05);
        chk(spi_cs_n == 8'hFA, "R9 cs set", {24'd0, spi_cs_n}, 32'hFA);

        for (int v = 0; v < 7; v++) begin
            lv = (32'(VEC[v][28:26]) * 8) << 24 | (32'(VEC[v][19:14]) * 8) << 12 | 32'(VEC[v][25:20]) * 8;
            run_xfer(VEC[v][31:30], VEC[v][29], VEC[v][13:2], lv,
                     int'(VEC[v][28:26]), int'(VEC[v][25:20]), int'(VEC[v][19:14]), v, 1'b0);
        end
        chk(spi_cs_n == 8'hFA, "R9 cs held across transfers", {24'd0, spi_cs_n}, 32'hFA);
        wr(6'h38, 32'h0);
        chk(spi_cs_n == 8'hFF, "R9 cs released", {24'd0, spi_cs_n}, 32'hFF);

        // R3 R8 rounding/clamping: cmd field 40 -> 4 bytes, rx field 13 -> 1 byte
        run_xfer(2'd1, 1'b0, 12'd1, (32'd40 << 24) | (32'd13 << 12), 4, 0, 1, 8, 1'b0);

        // R10 writes while busy ignored
        run_xfer(2'd0, 1'b0, 12'd3, (32'd8 << 24) | (32'd16 << 12) | 32'd8, 1, 1, 2, 9, 1'b1);

        // R11 empty transaction, with R12 busy bit
        set_mode(2'd2, 1'b0, 12'd0);
        wr(6'h2C, 32'h0);
        wr(6'h00, 32'h100);
        rd(6'h00, r);
        chk(r == 32'h0001_0000, "R11/R12 busy one cycle", r, 32'h0001_0000);
        @(negedge clk);
        rd(6'h00, r);
        chk(r == 32'd0, "R11 busy dropped", r, 32'd0);
        chk(lead_n == 0 && spi_sck == 1'b1, "R11 no sck edge", 32'(lead_n), 32'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule